// File: doc/BRIEF.md
# Descriptor-Driven Float Histogram Engine

This block takes one job descriptor at a time and builds a histogram of single-precision floating-point samples kept in a shared, word-addressed memory. The descriptor carries three byte addresses: where the samples live, where the sorted bin boundaries live, and where the resulting counters go. It also carries how many samples there are and how many bins to produce. The engine first confirms that every address falls on a memory-word boundary. It turns each address into a word index and fetches the boundaries into local registers. It then streams the samples past a parallel comparator and writes the 32-bit counters back into memory, several to a word. The job ends with a one-beat response that reports success or an address fault.

Memory is reached through a simple request port with a valid/ready handshake. The same port carries both reads and writes, and a separate read-data valid strobe returns the data. Only one read is ever outstanding. Several 32-bit elements share each memory word, and element 0 occupies the lowest 32 bits.

Top module: `hist_engine`

## Requirements
- R1: After reset, and between jobs, the engine is idle: `cmd_ready` is 1, `rsp_valid` is 0 and no memory request is raised. A descriptor is taken on the cycle where `cmd_valid` and `cmd_ready` are both 1, and no other descriptor is taken until its response has been accepted.
- R2: A byte address is aligned when it is a multiple of DW/8. All three descriptor addresses are checked.
- R3: If any of the three addresses is misaligned, the engine makes no memory read or write. It then returns exactly one response with status 1 (address error) and `rsp_last` set to 1.
- R4: An aligned byte address is used as a word index equal to the address divided by DW/8. The engine reads exactly ceil(nsamp / (DW/32)) words, starting at the sample word index.
- R5: Boundaries are fetched only when nbins > 1. In that case exactly nbins-1 boundaries are fetched, taking ceil((nbins-1) / (DW/32)) words starting at the boundary word index.
- R6: A sample is placed in bin k, where k is the number of boundaries less than or equal to it under floating-point ordering. Values below the first boundary therefore land in bin 0, and values at or above the last boundary land in bin nbins-1.
- R7: The engine writes exactly ceil(nbins / (DW/32)) words, starting at the count word index. Each 32-bit lane holds one unsigned counter, and no other memory word is written.
- R8: Within a memory word, element j occupies bits [32j+31:32j]. In the last written word, any lane beyond nbins is written as zero.
- R9: A job with aligned addresses ends with one response carrying status 0 (OK) and `rsp_last` set to 1. The engine then returns to idle.
- R10: A memory request holds its address and direction stable until it is accepted. No new request is raised while a read is outstanding.
- R11: A response holds its status until `rsp_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Descriptor valid |
| cmd_ready | output | 1 | Engine can take a descriptor |
| cmd_nsamp | input | CNT_W | Number of samples |
| cmd_nbins | input | NB_W | Number of bins (0..MAX_BINS) |
| cmd_samp_addr | input | AW | Byte address of the samples |
| cmd_edge_addr | input | AW | Byte address of the bin boundaries |
| cmd_cnt_addr | input | AW | Byte address of the counter region |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_status | output | 2 | 0 = OK, 1 = address error |
| rsp_last | output | 1 | End-of-response flag |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW-log2(DW/8) | Word index |
| mem_req_wdata | output | DW | Write data |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | DW | Read data |

## Verification
The bench sweeps every bin count from 0 to MAX_BINS against sample counts of zero, one, odd, even and more than one word. This covers the no-boundary and single-bin paths, partly filled last words on both reads and writes, and empty sample sets. The samples are signed integers, some of which equal a boundary exactly, so the bench can tell sign-magnitude float ordering apart from plain unsigned compares and `<=` apart from `<`. The base addresses shift from job to job, so the bench can tell a wrong byte-to-word conversion apart from a fixed offset. Guard words around the counter region catch writes beyond its end. A separate sweep misaligns each of the three addresses in turn by several offsets. It expects zero memory traffic and an untouched counter region.

// File: rtl/hist_pkg.sv
package hist_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CHECK,
        S_EDGE_REQ,
        S_EDGE_WAIT,
        S_SAMP_REQ,
        S_SAMP_WAIT,
        S_SAMP_BIN,
        S_WRITE,
        S_RESP
    } hist_state_e;

    localparam logic [1:0] STAT_OK       = 2'd0;
    localparam logic [1:0] STAT_ADDR_ERR = 2'd1;

    // Map an IEEE single to an unsigned key with the same ordering.
    function automatic logic [31:0] order_key(input logic [31:0] f);
        return f[31] ? ~f : {1'b1, f[30:0]};
    endfunction

endpackage

// File: rtl/hist_addr_check.sv
module hist_addr_check #(
    parameter int AW  = 16,
    parameter int OFS = 3,
    parameter int N   = 3,
    localparam int IW = AW - OFS
) (
    input  logic [N-1:0][AW-1:0] byte_addr,
    output logic                 aligned,
    output logic [N-1:0][IW-1:0] word_idx
);

    logic [N-1:0] ok;

    for (genvar i = 0; i < N; i++) begin : g_addr
        assign ok[i]       = (byte_addr[i][OFS-1:0] == '0);
        assign word_idx[i] = byte_addr[i][AW-1:OFS];
    end

    assign aligned = &ok;

endmodule

// File: rtl/hist_binner.sv
module hist_binner
    import hist_pkg::*;
#(
    parameter int NE   = 7,
    parameter int NB_W = 4
) (
    input  logic [31:0]         sample,
    input  logic [NE-1:0][31:0] edges,
    input  logic [NB_W-1:0]     n_edges,
    output logic [NB_W-1:0]     bin
);

    always_comb begin
        int cnt;
        cnt = 0;
        for (int i = 0; i < NE; i++) begin
            if (i < int'(n_edges) && order_key(edges[i]) <= order_key(sample))
                cnt++;
        end
        bin = NB_W'(cnt);
    end

endmodule

// File: rtl/hist_word_pack.sv
module hist_word_pack #(
    parameter int LANES    = 2,
    parameter int MAX_BINS = 8,
    parameter int CNT_W    = 16,
    parameter int NB_W     = 4,
    localparam int DW      = LANES * 32
) (
    input  logic [MAX_BINS-1:0][31:0] counts,
    input  logic [CNT_W-1:0]          word_ofs,
    input  logic [NB_W-1:0]           nbins,
    output logic [DW-1:0]             wdata
);

    always_comb begin
        wdata = '0;
        for (int j = 0; j < LANES; j++) begin
            for (int k = 0; k < MAX_BINS; k++) begin
                if (k == int'(word_ofs) * LANES + j && k < int'(nbins))
                    wdata[32*j +: 32] = counts[k];
            end
        end
    end

endmodule

// File: rtl/hist_engine.sv
module hist_engine
    import hist_pkg::*;
#(
    parameter int DW       = 64,
    parameter int AW       = 16,
    parameter int MAX_BINS = 8,
    parameter int CNT_W    = 16,
    localparam int LANES   = DW / 32,
    localparam int WB      = DW / 8,
    localparam int OFS     = $clog2(WB),
    localparam int IW      = AW - OFS,
    localparam int NB_W    = $clog2(MAX_BINS + 1),
    localparam int NE      = MAX_BINS - 1,
    localparam int LN_W    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [CNT_W-1:0] cmd_nsamp,
    input  logic [NB_W-1:0]  cmd_nbins,
    input  logic [AW-1:0]    cmd_samp_addr,
    input  logic [AW-1:0]    cmd_edge_addr,
    input  logic [AW-1:0]    cmd_cnt_addr,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [1:0]       rsp_status,
    output logic             rsp_last,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_req_we,
    output logic [IW-1:0]    mem_req_addr,
    output logic [DW-1:0]    mem_req_wdata,
    input  logic             mem_rd_valid,
    input  logic [DW-1:0]    mem_rd_data
);

    typedef struct packed {
        hist_state_e               state;
        logic [CNT_W-1:0]          nsamp;
        logic [NB_W-1:0]           nbins;
        logic [2:0][AW-1:0]        addr;
        logic [CNT_W-1:0]          elem;
        logic [CNT_W-1:0]          wofs;
        logic [LN_W-1:0]           lane;
        logic [DW-1:0]             word;
        logic [NE-1:0][31:0]       edges;
        logic [MAX_BINS-1:0][31:0] counts;
        logic [1:0]                status;
    } eng_t;

    eng_t q, d;

    logic                aligned;
    logic [2:0][IW-1:0]  widx;
    logic [31:0]         cur_sample;
    logic [NB_W-1:0]     n_edges;
    logic [NB_W-1:0]     bin;
    logic                to_samp, to_write;

    hist_addr_check #(.AW(AW), .OFS(OFS), .N(3)) u_addr (
        .byte_addr (q.addr),
        .aligned   (aligned),
        .word_idx  (widx)
    );

    assign n_edges = (q.nbins == '0) ? '0 : q.nbins - NB_W'(1);

    always_comb begin
        cur_sample = '0;
        for (int j = 0; j < LANES; j++)
            if (int'(q.lane) == j) cur_sample = q.word[32*j +: 32];
    end

    hist_binner #(.NE(NE), .NB_W(NB_W)) u_bin (
        .sample  (cur_sample),
        .edges   (q.edges),
        .n_edges (n_edges),
        .bin     (bin)
    );

    hist_word_pack #(.LANES(LANES), .MAX_BINS(MAX_BINS), .CNT_W(CNT_W), .NB_W(NB_W)) u_pack (
        .counts   (q.counts),
        .word_ofs (q.wofs),
        .nbins    (q.nbins),
        .wdata    (mem_req_wdata)
    );

    always_comb begin
        d        = q;
        to_samp  = 1'b0;
        to_write = 1'b0;
        case (q.state)
            S_IDLE: if (cmd_valid) begin
                d.nsamp   = cmd_nsamp;
                d.nbins   = cmd_nbins;
                d.addr[0] = cmd_samp_addr;
                d.addr[1] = cmd_edge_addr;
                d.addr[2] = cmd_cnt_addr;
                d.state   = S_CHECK;
            end
            S_CHECK: begin
                if (!aligned) begin
                    d.status = STAT_ADDR_ERR;
                    d.state  = S_RESP;
                end else begin
                    d.status = STAT_OK;
                    d.counts = '0;
                    d.elem   = '0;
                    d.wofs   = '0;
                    if (int'(q.nbins) > 1) d.state = S_EDGE_REQ;
                    else                   to_samp = 1'b1;
                end
            end
            S_EDGE_REQ: if (mem_req_ready) begin
                d.wofs  = q.wofs + CNT_W'(1);
                d.state = S_EDGE_WAIT;
            end
            S_EDGE_WAIT: if (mem_rd_valid) begin
                for (int k = 0; k < NE; k++)
                    for (int j = 0; j < LANES; j++)
                        if (int'(q.elem) + j == k) d.edges[k] = mem_rd_data[32*j +: 32];
                d.elem = q.elem + CNT_W'(LANES);
                if (int'(q.elem) + LANES >= int'(q.nbins) - 1) to_samp = 1'b1;
                else                                          d.state = S_EDGE_REQ;
            end
            S_SAMP_REQ: if (mem_req_ready) begin
                d.wofs  = q.wofs + CNT_W'(1);
                d.state = S_SAMP_WAIT;
            end
            S_SAMP_WAIT: if (mem_rd_valid) begin
                d.word  = mem_rd_data;
                d.lane  = '0;
                d.state = S_SAMP_BIN;
            end
            S_SAMP_BIN: begin
                for (int k = 0; k < MAX_BINS; k++)
                    if (int'(bin) == k) d.counts[k] = q.counts[k] + 32'd1;
                d.elem = q.elem + CNT_W'(1);
                if (int'(q.elem) + 1 >= int'(q.nsamp)) to_write = 1'b1;
                else if (int'(q.lane) == LANES - 1)    d.state = S_SAMP_REQ;
                else                                   d.lane = q.lane + LN_W'(1);
            end
            S_WRITE: if (mem_req_ready) begin
                d.wofs = q.wofs + CNT_W'(1);
                if ((int'(q.wofs) + 1) * LANES >= int'(q.nbins)) d.state = S_RESP;
            end
            S_RESP: if (rsp_ready) d.state = S_IDLE;
            default: d.state = S_IDLE;
        endcase

        if (to_samp) begin
            d.elem = '0;
            d.wofs = '0;
            if (q.nsamp == '0) to_write = 1'b1;
            else               d.state = S_SAMP_REQ;
        end
        if (to_write) begin
            d.wofs  = '0;
            d.state = (q.nbins == '0) ? S_RESP : S_WRITE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cmd_ready     = (q.state == S_IDLE);
    assign rsp_valid     = (q.state == S_RESP);
    assign rsp_last      = (q.state == S_RESP);
    assign rsp_status    = q.status;
    assign mem_req_valid = (q.state == S_EDGE_REQ) || (q.state == S_SAMP_REQ) || (q.state == S_WRITE);
    assign mem_req_we    = (q.state == S_WRITE);

    always_comb begin
        case (q.state)
            S_EDGE_REQ: mem_req_addr = widx[1] + IW'(q.wofs);
            S_SAMP_REQ: mem_req_addr = widx[0] + IW'(q.wofs);
            default:    mem_req_addr = widx[2] + IW'(q.wofs);
        endcase
    end

endmodule

// File: rtl/hist_engine_chk.sv
module hist_engine_chk #(
    parameter int DW = 64,
    parameter int AW = 16,
    localparam int OFS = $clog2(DW / 8),
    localparam int IW  = AW - OFS
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [AW-1:0] cmd_samp_addr,
    input logic [AW-1:0] cmd_edge_addr,
    input logic [AW-1:0] cmd_cnt_addr,
    input logic          rsp_valid,
    input logic          rsp_ready,
    input logic [1:0]    rsp_status,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic          mem_req_we,
    input logic [IW-1:0] mem_req_addr,
    input logic          mem_rd_valid
);

    logic busy_q, bad_q, rd_out_q;
    logic cmd_bad;

    assign cmd_bad = (cmd_samp_addr[OFS-1:0] != '0) || (cmd_edge_addr[OFS-1:0] != '0) ||
                     (cmd_cnt_addr[OFS-1:0] != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            bad_q    <= 1'b0;
            rd_out_q <= 1'b0;
        end else begin
            if (cmd_valid && cmd_ready) begin
                busy_q <= 1'b1;
                bad_q  <= cmd_bad;
            end else if (rsp_valid && rsp_ready) begin
                busy_q <= 1'b0;
                bad_q  <= 1'b0;
            end
            if (mem_req_valid && mem_req_ready && !mem_req_we) rd_out_q <= 1'b1;
            else if (mem_rd_valid)                             rd_out_q <= 1'b0;
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!mem_req_valid && !rsp_valid));

    a_r3_no_mem_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && bad_q) |-> !mem_req_valid);

    a_r3_error_status: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && bad_q) |-> (rsp_status == 2'd1));

    a_r9_ok_status: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && busy_q && !bad_q) |-> (rsp_status == 2'd0));

    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

    a_r10_one_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_out_q |-> !mem_req_valid);

    a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status)));

endmodule

bind hist_engine hist_engine_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_samp_addr (cmd_samp_addr),
    .cmd_edge_addr (cmd_edge_addr),
    .cmd_cnt_addr  (cmd_cnt_addr),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_status    (rsp_status),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_rd_valid  (mem_rd_valid)
);

// File: tb/tb_hist_engine.sv
`timescale 1ns/1ps
module tb_hist_engine;

    localparam int DW = 64, AW = 16, MAX_BINS = 8, CNT_W = 16;
    localparam int NB_W = 4, IW = 13;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst_n, cmd_valid, cmd_ready, rsp_valid, rsp_ready, rsp_last;
    logic [CNT_W-1:0] cmd_nsamp;
    logic [NB_W-1:0]  cmd_nbins;
    logic [AW-1:0]    cmd_samp_addr, cmd_edge_addr, cmd_cnt_addr;
    logic [1:0]       rsp_status;
    logic             mem_req_valid, mem_req_ready, mem_req_we, mem_rd_valid;
    logic [IW-1:0]    mem_req_addr;
    logic [DW-1:0]    mem_req_wdata, mem_rd_data;

    hist_engine #(.DW(DW), .AW(AW), .MAX_BINS(MAX_BINS), .CNT_W(CNT_W)) dut (.*);

    // memory model
    logic [63:0] mem [0:63];
    logic [7:0]  lfsr;
    int          n_rd, n_wr, n_wr_out, win_lo, win_hi;
    logic        pl_we;
    int          pl_addr;
    logic [63:0] pl_data;

    assign mem_req_ready = lfsr[0] | lfsr[3];

    always @(posedge clk) begin
        if (!rst_n) begin
            lfsr <= 8'hA5; mem_rd_valid <= 1'b0; n_rd <= 0; n_wr <= 0; n_wr_out <= 0;
        end else begin
            lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            mem_rd_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_we) begin
                    mem[mem_req_addr[5:0]] <= mem_req_wdata;
                    n_wr <= n_wr + 1;
                    if (int'(mem_req_addr) < win_lo || int'(mem_req_addr) >= win_hi)
                        n_wr_out <= n_wr_out + 1;
                end else begin
                    mem_rd_data  <= mem[mem_req_addr[5:0]];
                    mem_rd_valid <= 1'b1;
                    n_rd <= n_rd + 1;
                end
            end
        end
        if (pl_we) mem[pl_addr[5:0]] <= pl_data;
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] i2f(input int v);
        int m, e;
        logic [31:0] man;
        if (v == 0) return 32'h0;
        m = (v < 0) ? -v : v;
        e = 0;
        for (int b = 0; b < 24; b++) if (((m >> b) & 1) != 0) e = b;
        man = 32'(m << (23 - e)) & 32'h007F_FFFF;
        return {(v < 0), 8'(e + 127), man[22:0]};
    endfunction

    function automatic logic [63:0] sentinel(input int a);
        return 64'hA5A5_5A5A_0000_0000 | 64'(a);
    endfunction

    int s_val [0:15];
    int e_val [0:7];

    task automatic load_mem(input int ns, input int nb, input int sw, input int ew);
        for (int a = 0; a < 48; a++) begin
            logic [63:0] v;
            v = sentinel(a);
            for (int j = 0; j < 2; j++) begin
                int si, ei;
                si = (a - sw) * 2 + j;
                ei = (a - ew) * 2 + j;
                if (a >= sw && si < ns)     v[32*j +: 32] = i2f(s_val[si]);
                if (a >= ew && ei < nb - 1) v[32*j +: 32] = i2f(e_val[ei]);
            end
            @(negedge clk);
            pl_we = 1'b1; pl_addr = a; pl_data = v;
        end
        @(negedge clk);
        pl_we = 1'b0;
    endtask

    task automatic run_cmd(input int ns, input int nb, input int sa, input int ea, input int ca,
                           output logic [1:0] st, output int dr, output int dw, output int dout);
        int r0, w0, o0;
        logic [1:0] st0;
        r0 = n_rd; w0 = n_wr; o0 = n_wr_out;
        win_lo = ca / 8; win_hi = ca / 8 + (nb + 1) / 2;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_nsamp = CNT_W'(ns); cmd_nbins = NB_W'(nb);
        cmd_samp_addr = AW'(sa); cmd_edge_addr = AW'(ea); cmd_cnt_addr = AW'(ca);
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        st0 = rsp_status;
        chk(rsp_last == 1'b1, "R9", "last flag", longint'(rsp_last), 1);
        @(negedge clk);
        chk(rsp_valid && rsp_status == st0, "R11", "response held", longint'(rsp_status), longint'(st0));
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(cmd_ready == 1'b1, "R1", "idle after response", longint'(cmd_ready), 1);
        st = st0; dr = n_rd - r0; dw = n_wr - w0; dout = n_wr_out - o0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int ns_set [0:5];
        logic [1:0] st;
        int dr, dw, dout;
        ns_set = '{0, 1, 3, 4, 7, 12};
        rst_n = 1'b0; cmd_valid = 1'b0; rsp_ready = 1'b0; pl_we = 1'b0; pl_addr = 0; pl_data = '0;
        cmd_nsamp = '0; cmd_nbins = '0; cmd_samp_addr = '0; cmd_edge_addr = '0; cmd_cnt_addr = '0;
        win_lo = 0; win_hi = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R1", "reset cmd_ready", longint'(cmd_ready), 1);
        chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", longint'(rsp_valid), 0);
        chk(mem_req_valid == 1'b0, "R1", "reset mem_req_valid", longint'(mem_req_valid), 0);

        // sweep of bin and sample counts (R4..R9)
        for (int nb = 0; nb <= MAX_BINS; nb++) begin
            for (int t = 0; t < 6; t++) begin
                int ns, sw, ew, cw, nw;
                int expc [0:7];
                ns = ns_set[t];
                sw = 2 + (nb % 2); ew = 16 + (t % 3); cw = 24 + (nb % 3);
                nw = (nb + 1) / 2;
                for (int i = 0; i < 16; i++) s_val[i] = ((i * 7 + nb * 3 + t) % 23) - 11;
                for (int k = 0; k < 8; k++) e_val[k] = -9 + 3 * k;
                for (int k = 0; k < 8; k++) expc[k] = 0;
                for (int i = 0; i < ns; i++) begin
                    int b;
                    b = 0;
                    for (int k = 0; k < nb - 1; k++) if (e_val[k] <= s_val[i]) b++;
                    if (nb > 0) expc[b]++;
                end
                load_mem(ns, nb, sw, ew);
                run_cmd(ns, nb, sw * 8, ew * 8, cw * 8, st, dr, dw, dout);
                chk(st == 2'd0, "R9", "status ok", longint'(st), 0);
                chk(dr == (ns + 1) / 2 + ((nb > 1) ? nb / 2 : 0), "R4 R5", "read words",
                    dr, (ns + 1) / 2 + ((nb > 1) ? nb / 2 : 0));
                chk(dw == nw, "R7", "write words", dw, nw);
                chk(dout == 0, "R7", "writes outside counter region", dout, 0);
                for (int w = 0; w < nw; w++) begin
                    logic [63:0] ew64;
                    for (int j = 0; j < 2; j++)
                        ew64[32*j +: 32] = (2 * w + j < nb) ? 32'(expc[2 * w + j]) : 32'h0;
                    chk(mem[cw + w] === ew64, "R6 R8", "counter word", mem[cw + w], ew64);
                end
                chk(mem[cw + nw] === sentinel(cw + nw), "R7", "guard word",
                    mem[cw + nw], sentinel(cw + nw));
            end
        end

        // misaligned address sweep (R2, R3)
        for (int which = 0; which < 3; which++) begin
            for (int oi = 0; oi < 3; oi++) begin
                int off, sa, ea, ca;
                off = (oi == 0) ? 1 : (oi == 1) ? 4 : 7;
                for (int i = 0; i < 16; i++) s_val[i] = i - 5;
                load_mem(4, 5, 2, 16);
                sa = 16 + ((which == 0) ? off : 0);
                ea = 128 + ((which == 1) ? off : 0);
                ca = 192 + ((which == 2) ? off : 0);
                run_cmd(4, 5, sa, ea, ca, st, dr, dw, dout);
                chk(st == 2'd1, "R3", "address error status", longint'(st), 1);
                chk(dr + dw == 0, "R2 R3", "memory accesses", dr + dw, 0);
                chk(mem[24] === sentinel(24), "R3", "counter region untouched", mem[24], sentinel(24));
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule